// File: doc/BRIEF.md
# Iterative SIMON 64/128 Encryptor with Round Keys Derived Alongside the Rounds

This block encrypts a single 64-bit plaintext under a 128-bit key with the SIMON 64/128 cipher. A start request carries the plaintext and the key together. The next 44 clock cycles each run one cipher round. The round key for each round is produced in that same cycle from a four-word key register, so the block has no key setup phase before the first round.

When the last round completes, the block raises a one-cycle done pulse. The ciphertext is then available on its output and stays there until the next start is accepted. A start request that arrives while a block is in flight is dropped and has no effect on the running encryption. Decryption, modes of operation and bus attachment belong to the surrounding logic.

Top module: `simon64_otf_enc`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `ciphertext_o` is all zeros.
- R2: When `start_i` is 1 while `busy_o` is 0, the block captures `plaintext_i` and `key_i` at that clock edge, and `busy_o` is 1 from the next cycle.
- R3: `done_o` rises exactly 44 clock edges after the edge that accepted the start. That is one round per cycle with no extra key setup cycle.
- R4: `done_o` is high for exactly one cycle, and `busy_o` is 0 in that cycle.
- R5: `ciphertext_o` equals SIMON 64/128 encryption of the accepted inputs. The bit fields are:
  - `plaintext_i[63:32]` is the left word and `plaintext_i[31:0]` is the right word.
  - In each round: new left = right ^ (rotl1(left) & rotl8(left)) ^ rotl2(left) ^ round key; new right = old left.
  - `ciphertext_o` has the same left/right layout as the plaintext.
- R6: Round i uses key word k[i]. `key_i[32*j+31:32*j]` is k[j] for j = 0..3. Later words are built as follows:
  - t = rotr3(k[i+3]) ^ k[i+1]
  - k[i+4] = 0xFFFFFFFC ^ z[i] ^ k[i] ^ t ^ rotr1(t)
  - z[i] is bit i of the 62-bit constant sequence 11011011101011000110010111100000010010001010011100110100001111, taken leftmost first and indexed modulo 62.
- R7: A start request while `busy_o` is 1 is ignored. The result and the done timing are those of the original inputs.
- R8: After `done_o`, `ciphertext_o` holds its value until the next start is accepted. A start presented in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to encrypt the presented inputs |
| plaintext_i | input | 64 | Plaintext block, left word in the upper half |
| key_i | input | 128 | Cipher key, first round key in the lowest word |
| busy_o | output | 1 | An encryption is in progress |
| done_o | output | 1 | One-cycle pulse when the ciphertext is ready |
| ciphertext_o | output | 64 | Result, valid from the done pulse until the next accepted start |

## Verification
The assertions assume that `start_i` is a clean, defined level sampled at the rising edge. They make no assumption on when a request arrives, because the block itself must drop requests made while busy. The stimulus changes inputs only at falling edges. It presents requests in three situations: while idle, in the done cycle, and in the middle of a run. In the mid-run case the plaintext and key buses are also changed, so that a dropped request would show in the result.

// File: rtl/simon64_pkg.sv
package simon64_pkg;

  localparam int unsigned HALF_W  = 32;
  localparam int unsigned KWORDS  = 4;
  localparam int unsigned SEQ_LEN = 62;

  typedef logic [HALF_W-1:0] word_t;

  // constant sequence, bit i is the value used when deriving word i+4
  localparam logic [SEQ_LEN-1:0] Z_SEQ  = 62'h3C2CE51207A635DB;
  localparam word_t              K_BASE = 32'hFFFF_FFFC;

  function automatic word_t rotl(word_t v, int unsigned s);
    return (v << s) | (v >> (HALF_W - s));
  endfunction

  function automatic word_t rotr(word_t v, int unsigned s);
    return (v >> s) | (v << (HALF_W - s));
  endfunction

  // new left word of one round
  function automatic word_t round_mix(word_t l, word_t r, word_t k);
    return r ^ (rotl(l, 1) & rotl(l, 8)) ^ rotl(l, 2) ^ k;
  endfunction

  function automatic logic seq_bit(int unsigned idx);
    logic [5:0] pos;
    pos = 6'(idx % SEQ_LEN);
    return Z_SEQ[pos];
  endfunction

  // next key word from the oldest, second and newest words
  function automatic word_t key_extend(word_t k0, word_t k1, word_t k3, logic zb);
    word_t t;
    t = rotr(k3, 3) ^ k1;
    return K_BASE ^ {{(HALF_W-1){1'b0}}, zb} ^ k0 ^ t ^ rotr(t, 1);
  endfunction

endpackage

// File: rtl/simon_ctrl.sv
module simon_ctrl #(
  parameter int unsigned ROUNDS = 44,
  parameter int unsigned CNT_W  = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic             last_o,
  output logic [CNT_W-1:0] round_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);

  typedef enum logic {ST_IDLE, ST_RUN} st_t;

  st_t              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign load_o  = start_i && (st_q == ST_IDLE);
  assign step_o  = (st_q == ST_RUN);
  assign last_o  = step_o && (cnt_q == LAST_RND);
  assign round_o = cnt_q;
  assign busy_o  = step_o;
  assign done_o  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        st_q  <= ST_RUN;
        cnt_q <= '0;
      end else if (last_o) begin
        st_q <= ST_IDLE;
      end else if (step_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt_q <= LAST_RND));
  assert_first_round_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (busy_o && cnt_q == '0));
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_ignore_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_o) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/simon_key_sched.sv
module simon_key_sched
  import simon64_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic                     step_i,
  input  logic [KWORDS*HALF_W-1:0] key_i,
  input  logic [CNT_W-1:0]         round_i,
  output word_t                    rk_o
);

  word_t kq [KWORDS];
  word_t k_new;
  logic  zb;

  assign zb    = seq_bit(int'(round_i));
  assign k_new = key_extend(kq[0], kq[1], kq[KWORDS-1], zb);
  assign rk_o  = kq[0];

  for (genvar j = 0; j < KWORDS; j++) begin : g_kw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        kq[j] <= '0;
      end else if (load_i) begin
        kq[j] <= key_i[j*HALF_W +: HALF_W];
      end else if (step_i) begin
        if (j == KWORDS-1) kq[j] <= k_new;
        else               kq[j] <= kq[(j+1) % KWORDS];
      end
    end
  end

  assert_key_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (kq[0] == $past(kq[1])));
  assert_key_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(kq[0]));

endmodule

// File: rtl/simon_round_dp.sv
module simon_round_dp
  import simon64_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic                  step_i,
  input  logic [2*HALF_W-1:0]   pt_i,
  input  word_t                 rk_i,
  output logic [2*HALF_W-1:0]   state_o
);

  word_t left_q, right_q;
  word_t left_nx;

  assign left_nx = round_mix(left_q, right_q, rk_i);
  assign state_o = {left_q, right_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
    end else if (load_i) begin
      left_q  <= pt_i[2*HALF_W-1:HALF_W];
      right_q <= pt_i[HALF_W-1:0];
    end else if (step_i) begin
      left_q  <= left_nx;
      right_q <= left_q;
    end
  end

  assert_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (right_q == $past(left_q)));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(state_o));

endmodule

// File: rtl/simon64_otf_enc.sv
module simon64_otf_enc
  import simon64_pkg::*;
#(
  parameter int unsigned ROUNDS = 44,
  parameter int unsigned CNT_W  = $clog2(ROUNDS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [63:0]  plaintext_i,
  input  logic [127:0] key_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [63:0]  ciphertext_o
);

  logic             load_w, step_w, last_w;
  logic [CNT_W-1:0] round_w;
  word_t            rk_w;

  simon_ctrl #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load_w),
    .step_o  (step_w),
    .last_o  (last_w),
    .round_o (round_w),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  simon_key_sched #(.CNT_W(CNT_W)) u_keys (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_w),
    .step_i  (step_w),
    .key_i   (key_i),
    .round_i (round_w),
    .rk_o    (rk_w)
  );

  simon_round_dp u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_w),
    .step_i  (step_w),
    .pt_i    (plaintext_i),
    .rk_i    (rk_w),
    .state_o (ciphertext_o)
  );

  assert_done_follows_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |=> done_o);
  assert_no_spurious_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !last_w |=> !done_o);

endmodule

// File: tb/simon64_otf_enc_bench.sv
module simon64_otf_enc_bench;

  localparam int ROUNDS = 44;
  localparam logic [61:0] ZSTR =
    62'b11011011101011000110010111100000010010001010011100110100001111;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [63:0]  plaintext_i = '0;
  logic [127:0] key_i = '0;
  logic         busy_o, done_o;
  logic [63:0]  ciphertext_o;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  simon64_otf_enc u_simon64_otf_enc (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .plaintext_i(plaintext_i),
    .key_i(key_i), .busy_o(busy_o), .done_o(done_o), .ciphertext_o(ciphertext_o)
  );

  function automatic logic [63:0] ref_enc(logic [63:0] pt, logic [127:0] key);
    logic [31:0] ks [ROUNDS];
    logic [31:0] x, y, nx, tmp, f;
    for (int i = 0; i < 4; i++) ks[i] = key[32*i +: 32];
    for (int i = 4; i < ROUNDS; i++) begin
      tmp   = {ks[i-1][2:0], ks[i-1][31:3]} ^ ks[i-3];
      ks[i] = ~ks[i-4] ^ tmp ^ {tmp[0], tmp[31:1]} ^ 32'd3
              ^ {31'd0, ZSTR[61 - ((i-4) % 62)]};
    end
    x = pt[63:32];
    y = pt[31:0];
    for (int i = 0; i < ROUNDS; i++) begin
      f  = ({x[30:0], x[31]} & {x[23:0], x[31:24]}) ^ {x[29:0], x[31:30]};
      nx = y ^ f ^ ks[i];
      y  = x;
      x  = nx;
    end
    return {x, y};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drives a start at the current falling edge; returns at the falling edge after done
  task automatic run_one(logic [63:0] pt, logic [127:0] key, bit mid_start, bit hold);
    logic [63:0] exp;
    exp = ref_enc(pt, key);
    plaintext_i = pt;
    key_i       = key;
    start_i     = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after accept", {63'd0, busy_o}, 64'd1);
    for (int k = 1; k <= ROUNDS; k++) begin
      if (mid_start && k == 10) begin
        plaintext_i = ~pt;
        key_i       = {key[63:0], key[127:64]};
        start_i     = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
      if (k < ROUNDS) begin
        if (done_o !== 1'b0) check("R3 early done", {63'd0, done_o}, 64'd0);
      end
    end
    check("R3 done at round count", {63'd0, done_o}, 64'd1);
    check("R4 idle in done cycle", {63'd0, busy_o}, 64'd0);
    check(mid_start ? "R7 ciphertext despite busy start" : "R5 R6 ciphertext", ciphertext_o, exp);
    if (hold) begin
      for (int g = 0; g < 3; g++) begin
        @(negedge clk);
        check("R4 done single cycle", {63'd0, done_o}, 64'd0);
        check("R8 ciphertext held", ciphertext_o, exp);
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 busy reset", {63'd0, busy_o}, 64'd0);
    check("R1 done reset", {63'd0, done_o}, 64'd0);
    check("R1 ciphertext reset", ciphertext_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // published vector
    run_one(64'h656b696c_20646e75,
            128'h1b1a1918_13121110_0b0a0908_03020100, 1'b0, 1'b1);
    check("R5 R6 known answer", ciphertext_o, 64'h44c8fc20_b9dfa07a);

    // corner values
    run_one(64'd0, 128'd0, 1'b0, 1'b1);
    run_one('1, '1, 1'b0, 1'b1);
    run_one(64'h8000_0000_0000_0001, 128'h1, 1'b1, 1'b1);

    // back-to-back: next start presented in the done cycle (R8)
    run_one(64'h0123_4567_89ab_cdef, 128'hfedc_ba98_7654_3210_0f1e_2d3c_4b5a_6978, 1'b0, 1'b0);
    run_one(64'hdead_beef_cafe_f00d, 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff, 1'b0, 1'b0);

    for (int v = 0; v < 30; v++) begin
      logic [63:0]  pt;
      logic [127:0] key;
      pt  = {$urandom(), $urandom()};
      key = {$urandom(), $urandom(), $urandom(), $urandom()};
      run_one(pt, key, (v % 4) == 1, (v % 3) != 0);
    end

    @(negedge clk);
    check("R4 done low after runs", {63'd0, done_o}, 64'd0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule